// File: doc/BRIEF.md
# SPI Bus Monitor with Frame Timeout

This block listens to the four wires of an SPI bus (slave select, serial clock and both data lines) without driving any of them. The four wires are first brought into the system clock domain through a chain of flip-flops. After that, serial-clock edges are detected by comparing each synchronized sample with the one taken a cycle earlier. Bits on the controller-to-peripheral line and on the peripheral-to-controller line are shifted in together on the selected sampling edge. Every completed byte appears on two separate byte outputs, one for each direction, under a single valid strobe.

Frames are marked by one-cycle start and end pulses. A frame normally opens when slave select falls and closes when it rises. Some peripherals keep select low across several transfers, so a programmable idle limit also closes the frame when no serial-clock edge arrives for that many system clocks. The next serial-clock edge then opens a new frame. This lets a command and the data that follows it be seen as two separate frames. A frame that closes while a byte is only partly shifted in raises a truncation pulse. The system clock must be several times faster than the bus; the synchronizer adds a fixed latency of a few cycles.

Top module: `spi_bus_monitor`

## Requirements
- R1: After reset, `byte_valid`, `frame_start`, `frame_end`, `end_by_idle` and `byte_trunc` are all low.
- R2: The sampling edge is the rising serial-clock edge when `cfg_cpol` equals `cfg_cpha`, and the falling edge otherwise. Bytes decode correctly in all four combinations of these two inputs.
- R3: Bits are shifted in most significant bit first. After the eighth sampling edge of a byte, `byte_valid` pulses for one cycle, with `byte_mosi` and `byte_miso` holding the bytes captured on the two data lines at the same time.
- R4: A falling edge on `spi_ss_n` produces a one-cycle `frame_start` pulse. `frame_start` and `frame_end` never pulse in the same cycle.
- R5: While `spi_ss_n` is high, serial-clock edges are ignored: no byte, no frame start and no bit counting.
- R6: With `cfg_idle_limit` = L > 0, slave select low and a frame open, if L system clocks pass with no serial-clock edge, `frame_end` pulses with `end_by_idle` = 1. Any serial-clock edge restarts the count.
- R7: After an idle close, the next serial-clock edge while `spi_ss_n` stays low pulses `frame_start`. The bit on that edge is still captured.
- R8: When a frame closes with 1 to 7 bits of a byte pending, `byte_trunc` pulses together with `frame_end`. The partial bits are discarded and the next frame starts with an empty byte.
- R9: `cfg_idle_limit` = 0 disables the idle close.
- R10: A rising edge on `spi_ss_n` while a frame is open always produces `frame_end` with `end_by_idle` = 0, even if the idle count has not expired. `frame_end` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | 0: sample on first clock edge, 1: on second |
| cfg_idle_limit | input | 16 | System clocks without a serial-clock edge that close a frame; 0 disables |
| spi_ss_n | input | 1 | Bus slave select, active low |
| spi_sck | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Controller-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-controller data |
| byte_valid | output | 1 | One-cycle strobe: a byte completed on both lines |
| byte_mosi | output | 8 | Byte captured on the controller-to-peripheral line |
| byte_miso | output | 8 | Byte captured on the peripheral-to-controller line |
| frame_start | output | 1 | One-cycle pulse when a frame opens |
| frame_end | output | 1 | One-cycle pulse when a frame closes |
| end_by_idle | output | 1 | With `frame_end`: 1 if the idle limit closed the frame |
| byte_trunc | output | 1 | With `frame_end`: a partial byte was dropped |

## Verification
The assertions check several properties on every cycle. Byte strobes, frame-end pulses and idle expiries last one cycle. Start and end never coincide. Truncation and the idle cause only appear on a frame-end pulse. Checking correct decoding needs the bench's scenarios. These cover bit order in all four clock modes, edges ignored while select is high, the exact delay from the last serial-clock edge to an idle close, the reopening of a frame under a held select, and the clean restart after a truncated byte.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
   // Cause reported with a frame-end pulse
   typedef enum logic {
      END_BY_SELECT = 1'b0,
      END_BY_IDLE   = 1'b1
   } end_cause_e;

   // Decoded edge events of the synchronized bus
   typedef struct packed {
      logic sel_fall;
      logic sel_rise;
      logic clk_rise;
      logic clk_fall;
   } bus_events_t;
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_mon_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_mon_shifter.sv
module spi_mon_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              clear,
   input  logic              bit_mosi,
   input  logic              bit_miso,
   output logic              done,
   output logic [BYTE_W-1:0] out_mosi,
   output logic [BYTE_W-1:0] out_miso,
   output logic              partial
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("spi_mon_shifter: BYTE_W must be at least 2");
   end

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] sh_mosi, sh_miso;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         sh_mosi  <= '0;
         sh_miso  <= '0;
         done     <= 1'b0;
         out_mosi <= '0;
         out_miso <= '0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            bit_cnt <= '0;
         end else if (sample) begin
            sh_mosi <= {sh_mosi[BYTE_W-2:0], bit_mosi};
            sh_miso <= {sh_miso[BYTE_W-2:0], bit_miso};
            if (bit_cnt == LAST) begin
               bit_cnt  <= '0;
               done     <= 1'b1;
               out_mosi <= {sh_mosi[BYTE_W-2:0], bit_mosi};
               out_miso <= {sh_miso[BYTE_W-2:0], bit_miso};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign partial = (bit_cnt != '0);

   // R3: a completed byte is announced for exactly one cycle
   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/spi_mon_idle_timer.sv
module spi_mon_idle_timer #(
   parameter int IDLE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              activity,
   input  logic [IDLE_W-1:0] limit,
   output logic              expire
);
   if (IDLE_W < 2) begin : g_bad_idle
      $error("spi_mon_idle_timer: IDLE_W must be at least 2");
   end

   logic [IDLE_W-1:0] idle_cnt;
   logic [IDLE_W:0]   cnt_plus;

   assign cnt_plus = {1'b0, idle_cnt} + {{IDLE_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idle_cnt <= '0;
      else if (!arm || activity)   idle_cnt <= '0;
      else if (!(&idle_cnt))       idle_cnt <= idle_cnt + 1'b1;
   end

   assign expire = arm && !activity && (limit != '0) &&
                   (cnt_plus == {1'b0, limit});

   // R6: an expiry is a single event; the frame it closes disarms the timer
   assert_expire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
   import spi_mon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter int IDLE_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [IDLE_W-1:0] cfg_idle_limit,
   input  logic              spi_ss_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_miso,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_mosi,
   output logic [BYTE_W-1:0] byte_miso,
   output logic              frame_start,
   output logic              frame_end,
   output logic              end_by_idle,
   output logic              byte_trunc
);
   localparam int         N_LINES   = 4;
   localparam int         L_SS      = 3;
   localparam int         L_SCK     = 2;
   localparam int         L_MOSI    = 1;
   localparam int         L_MISO    = 0;
   localparam logic [N_LINES-1:0] LINE_RST = 4'b1000;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_bus_monitor: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] raw, syn;
   assign raw = {spi_ss_n, spi_sck, spi_mosi, spi_miso};

   spi_mon_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (raw), .q (syn)
   );

   // Edge detection against previous synchronized sample
   logic        ss_q, sck_q;
   bus_events_t ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         ss_q  <= syn[L_SS];
         sck_q <= syn[L_SCK];
      end
   end

   assign ev.sel_fall = ss_q & ~syn[L_SS];
   assign ev.sel_rise = ~ss_q & syn[L_SS];
   assign ev.clk_rise = ~sck_q & syn[L_SCK];
   assign ev.clk_fall = sck_q & ~syn[L_SCK];

   logic sel_active, clk_edge, sample;
   assign sel_active = ~syn[L_SS];
   assign clk_edge   = ev.clk_rise | ev.clk_fall;
   assign sample     = sel_active &
                       ((cfg_cpol == cfg_cpha) ? ev.clk_rise : ev.clk_fall);

   // Frame control
   logic in_frame, open_now, close_sel, close_idle, close_any, expire, partial;

   assign open_now   = ev.sel_fall | (sel_active & ~in_frame & clk_edge);
   assign close_sel  = ev.sel_rise & in_frame;
   assign close_idle = expire;
   assign close_any  = close_sel | close_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         in_frame <= 1'b0;
      else if (close_any) in_frame <= 1'b0;
      else if (open_now)  in_frame <= 1'b1;
   end

   spi_mon_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (in_frame & sel_active),
      .activity (clk_edge),
      .limit    (cfg_idle_limit),
      .expire   (expire)
   );

   spi_mon_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample   (sample),
      .clear    (close_any | ev.sel_fall),
      .bit_mosi (syn[L_MOSI]),
      .bit_miso (syn[L_MISO]),
      .done     (byte_valid),
      .out_mosi (byte_mosi),
      .out_miso (byte_miso),
      .partial  (partial)
   );

   end_cause_e cause;
   assign cause = close_sel ? END_BY_SELECT : END_BY_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_start <= 1'b0;
         frame_end   <= 1'b0;
         end_by_idle <= 1'b0;
         byte_trunc  <= 1'b0;
      end else begin
         frame_start <= open_now & ~close_any;
         frame_end   <= close_any;
         end_by_idle <= close_any & (cause == END_BY_IDLE);
         byte_trunc  <= close_any & partial;
      end
   end

   // R4: a frame never opens and closes in the same cycle
   assert_start_end_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !frame_start);
   // R8: truncation is only reported on a frame end
   assert_trunc_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_trunc |-> frame_end);
   // R6: the idle cause only accompanies a frame end
   assert_idle_cause_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      end_by_idle |-> frame_end);
   // R10: frame end is a one-cycle pulse
   assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);
endmodule

// File: tb/test_spi_bus_monitor.sv
module test_spi_bus_monitor;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [15:0] cfg_idle_limit = '0;
   logic        spi_ss_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, spi_miso = 1'b0;
   logic        byte_valid, frame_start, frame_end, end_by_idle, byte_trunc;
   logic [7:0]  byte_mosi, byte_miso;

   always #2.5 clk = ~clk;

   spi_bus_monitor i_spi_bus_monitor (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_idle_limit(cfg_idle_limit), .spi_ss_n(spi_ss_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .byte_valid(byte_valid),
      .byte_mosi(byte_mosi), .byte_miso(byte_miso), .frame_start(frame_start),
      .frame_end(frame_end), .end_by_idle(end_by_idle), .byte_trunc(byte_trunc)
   );

   int n_checks = 0, n_fail = 0;
   int cyc = 0;
   int n_bytes = 0, n_start = 0, n_end = 0, n_idle = 0, n_trunc = 0;
   int end_cyc = 0, edge_cyc = 0;
   int mo_log [16];
   int mi_log [16];
   bit done_flag = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Observer samples away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin
            mo_log[n_bytes % 16] = int'(byte_mosi);
            mi_log[n_bytes % 16] = int'(byte_miso);
            n_bytes++;
         end
         if (frame_start) n_start++;
         if (frame_end) begin n_end++; end_cyc = cyc; end
         if (end_by_idle) n_idle++;
         if (byte_trunc) n_trunc++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic toggle_sck();
      spi_sck = ~spi_sck;
      edge_cyc = cyc;
   endtask

   task automatic send_bit(input logic mo, input logic mi);
      if (!cfg_cpha) begin
         spi_mosi = mo; spi_miso = mi;
         wait_clks(HALF); toggle_sck();
         wait_clks(HALF); toggle_sck();
      end else begin
         toggle_sck(); spi_mosi = mo; spi_miso = mi;
         wait_clks(HALF); toggle_sck();
         wait_clks(HALF);
      end
   endtask

   task automatic send_byte(input logic [7:0] mo, input logic [7:0] mi);
      for (int i = 7; i >= 0; i--) send_bit(mo[i], mi[i]);
   endtask

   task automatic set_mode(input logic pol, input logic pha);
      cfg_cpol = pol; cfg_cpha = pha; spi_sck = pol;
      wait_clks(10);
   endtask

   task automatic t_reset();
      chk(!byte_valid && !frame_start && !frame_end && !end_by_idle && !byte_trunc,
          "R1 outputs idle after reset",
          int'({byte_valid, frame_start, frame_end, end_by_idle, byte_trunc}), 0);
   endtask

   task automatic t_modes();
      for (int m = 0; m < 4; m++) begin
         int b0 = n_bytes, s0 = n_start, e0 = n_end, i0 = n_idle;
         logic [7:0] mo0 = 8'hA5 ^ 8'(m), mo1 = 8'h3C + 8'(m);
         logic [7:0] mi0 = 8'h5A, mi1 = 8'hC3 - 8'(m * 17);
         set_mode(m[1], m[0]);
         spi_ss_n = 1'b0; wait_clks(HALF);
         send_byte(mo0, mi0);
         send_byte(mo1, mi1);
         wait_clks(HALF); spi_ss_n = 1'b1; wait_clks(12);
         chk(n_bytes - b0 == 2, "R3 two bytes per frame", n_bytes - b0, 2);
         chk(mo_log[b0 % 16] == int'(mo0), "R2 mosi byte 0 in mode", mo_log[b0 % 16], int'(mo0));
         chk(mi_log[b0 % 16] == int'(mi0), "R3 miso byte 0 concurrent", mi_log[b0 % 16], int'(mi0));
         chk(mo_log[(b0 + 1) % 16] == int'(mo1), "R2 mosi byte 1 in mode", mo_log[(b0 + 1) % 16], int'(mo1));
         chk(mi_log[(b0 + 1) % 16] == int'(mi1), "R3 miso byte 1 MSB first", mi_log[(b0 + 1) % 16], int'(mi1));
         chk(n_start - s0 == 1, "R4 one start per select low", n_start - s0, 1);
         chk(n_end - e0 == 1 && n_idle == i0, "R10 select rise ends frame, cause select", n_end - e0, 1);
      end
   endtask

   task automatic t_ignored();
      int b0 = n_bytes, s0 = n_start, e0 = n_end;
      set_mode(1'b0, 1'b0);
      for (int i = 0; i < 20; i++) begin
         spi_mosi = i[0]; toggle_sck(); wait_clks(HALF);
      end
      wait_clks(10);
      chk(n_bytes == b0, "R5 no byte while select high", n_bytes - b0, 0);
      chk(n_start == s0 && n_end == e0, "R5 no frame while select high", n_start - s0, 0);
      spi_sck = 1'b0; wait_clks(10);
      spi_ss_n = 1'b0; wait_clks(HALF);
      send_byte(8'h96, 8'h69);
      wait_clks(HALF); spi_ss_n = 1'b1; wait_clks(12);
      chk(mo_log[b0 % 16] == 'h96, "R5 bit count untouched by ignored edges", mo_log[b0 % 16], 'h96);
   endtask

   task automatic t_trunc();
      int b0 = n_bytes, e0 = n_end, t0 = n_trunc;
      set_mode(1'b1, 1'b1);
      spi_ss_n = 1'b0; wait_clks(HALF);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      wait_clks(HALF); spi_ss_n = 1'b1; wait_clks(12);
      chk(n_trunc - t0 == 1, "R8 truncation flagged", n_trunc - t0, 1);
      chk(n_end - e0 == 1 && n_bytes == b0, "R8 partial byte dropped", n_bytes - b0, 0);
      spi_ss_n = 1'b0; wait_clks(HALF);
      send_byte(8'h81, 8'h7E);
      wait_clks(HALF); spi_ss_n = 1'b1; wait_clks(12);
      chk(mo_log[b0 % 16] == 'h81, "R8 next frame starts fresh", mo_log[b0 % 16], 'h81);
      chk(n_trunc - t0 == 1, "R8 full byte not truncated", n_trunc - t0, 1);
   endtask

   task automatic t_timeout();
      int b0 = n_bytes, s0 = n_start, e0 = n_end, i0 = n_idle;
      int lim = 40;
      int last;
      cfg_idle_limit = 16'(lim);
      set_mode(1'b0, 1'b1);
      spi_ss_n = 1'b0; wait_clks(HALF);
      send_byte(8'hC0, 8'h0C);
      last = edge_cyc;
      wait_clks(lim + 20);
      chk(n_end - e0 == 1 && n_idle - i0 == 1, "R6 idle limit closes frame", n_idle - i0, 1);
      chk(end_cyc - last >= lim + 2 && end_cyc - last <= lim + 4,
          "R6 idle close delay", end_cyc - last, lim + 3);
      send_byte(8'h3E, 8'hE3);
      wait_clks(HALF); spi_ss_n = 1'b1; wait_clks(12);
      chk(n_start - s0 == 2, "R7 clock edge reopens frame", n_start - s0, 2);
      chk(mo_log[(b0 + 1) % 16] == 'h3E, "R7 first bit of reopened frame kept",
          mo_log[(b0 + 1) % 16], 'h3E);
      chk(n_end - e0 == 2 && n_idle - i0 == 1, "R10 select rise cause", n_end - e0, 2);
   endtask

   task automatic t_disabled();
      int e0 = n_end, i0 = n_idle;
      cfg_idle_limit = 16'd0;
      set_mode(1'b0, 1'b0);
      spi_ss_n = 1'b0; wait_clks(HALF);
      send_byte(8'h11, 8'h22);
      wait_clks(300);
      chk(n_end == e0, "R9 limit zero never closes", n_end - e0, 0);
      spi_ss_n = 1'b1; wait_clks(12);
      chk(n_end - e0 == 1 && n_idle == i0, "R10 select rise closes frame", n_end - e0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(5);
      t_reset();
      t_modes();
      t_ignored();
      t_trunc();
      t_timeout();
      t_disabled();
      finish_run();
   end
endmodule